// File: doc/BRIEF.md
# Video Status Flags and NMI Race Logic

This block holds the three status flags of a video chip (vertical blank, sprite-zero hit, sprite overflow) and drives the NMI line toward the CPU. It runs on a master clock in which every cycle is one half-dot: the strobe `pclk0_i` marks the first half of a dot and `pclk1_i` the second. The scanline and dot positions come from the timing generator. Hit and overflow events come from the renderer. The CPU side is given as a chip select, R/W, the low address bits, the data bus and the M2 phase clock.

A status read is recognised only while M2 is high. The status byte is captured on the half-dot in which M2 rises and is held on `status_o`. The vertical-blank flag is cleared when that access ends on the falling edge of M2. A read whose M2 rise falls within a few half-dots of the moment the vertical-blank flag is set hits the familiar race. A read that starts before the set point returns 0, one that starts at or after it returns 1, and in either case NMI for that frame is withheld. NMI is raised only after the flag has stood for one half-dot more than the race window, so a racing read can never let a short NMI pulse through.

Top module: `ppu_status_nmi`

## Requirements
- R1: While `rst_ni` is low and after it is released, `status_o` is 8'h00 and `nmi_o` is 0.
- R2: The vertical-blank flag is set on the `pclk0_i` half-dot of line 241, dot 1. A read whose M2 rise lands on that half-dot or later returns 1 in bit 7. A read whose M2 rise lands earlier returns 0.
- R3: On the half-dot in which a status read's M2 rise occurs, `status_o` captures bit 7 vertical blank, bit 6 sprite-zero hit, bit 5 sprite overflow and bits 4:0 from the open-bus latch. It holds that value until the next status read.
- R4: A status read clears the vertical-blank flag on the cycle M2 falls. A later read returns 0 in bit 7 and `nmi_o` drops.
- R5: If a status read's M2 rise is within 6 half-dots of the set point, on either side, NMI stays low for the rest of the frame. At 7 or more half-dots away, NMI is not affected.
- R6: `nmi_o` is high only while the vertical-blank flag is set, `nmi_en_i` is high and the frame is not suppressed. It rises 7 half-dots after the set point, or at once when the enable is raised later.
- R7: A sprite-zero event given with `pclk0_i` of dot x sets bit 6 on the `pclk1_i` half-dot of dot x+2, and not before.
- R8: An overflow event given with `pclk0_i` of a dot sets bit 5 on the `pclk1_i` half-dot of the same dot.
- R9: On the `pclk0_i` half-dot of line 261, dot 1, all three flags and the NMI suppression are cleared, and `nmi_o` goes low.
- R10: A write (`sel_i`=1, `rw_i`=0, M2 high) to any register loads `data_i` into the open-bus latch. Its bits 4:0 appear in the low bits of the next status read.
- R11: A status read is decoded only when `sel_i`=1, `rw_i`=1 and `addr_i`=2 while M2 is high. Other accesses neither change `status_o` nor clear the vertical-blank flag.
- R12: Status reads do not clear the sprite-zero and overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, one half-dot per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk0_i | input | 1 | First half-dot strobe |
| pclk1_i | input | 1 | Second half-dot strobe |
| line_i | input | 9 | Current scanline |
| dot_i | input | 9 | Current dot in the line |
| m2_i | input | 1 | CPU M2 phase clock |
| sel_i | input | 1 | Register window chip select |
| rw_i | input | 1 | CPU read (1) or write (0) |
| addr_i | input | 3 | Register index |
| data_i | input | 8 | CPU write data |
| nmi_en_i | input | 1 | NMI enable bit |
| s0_hit_i | input | 1 | Sprite-zero hit event at the hit pixel |
| ovf_i | input | 1 | Sprite overflow event |
| status_o | output | 8 | Latched status byte |
| nmi_o | output | 1 | NMI request, active high |

## Verification
Some rules are checked by the assertions on every cycle. The vertical-blank flag only rises at the set point and only falls at a read end or at the pre-render clear. The hit and overflow flags only rise on a second-half strobe. NMI never stands without the enable and the flag. `status_o` changes only on a decoded read's M2 rise. Other behaviour needs the bench's scenarios to show it: the full sweep of read offsets from -8 to +8 half-dots around the set point (both the returned bit and whether NMI appears), the exact two-dot hit delay, open-bus contents, and the fact that reads leave the hit flags in place.

// File: rtl/ppu_stat_pkg.sv
package ppu_stat_pkg;
  localparam int unsigned NUM_HIT = 2;
  localparam int unsigned HIT_S0  = 0;
  localparam int unsigned HIT_OVF = 1;
  localparam int unsigned OB_W    = 5;
endpackage

// File: rtl/stat_bus.sv
module stat_bus #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic              sel_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              rd_start_o,
  output logic              rd_end_o,
  output logic [7:0]        ob_o
);
  logic io_ce_n, m2_q, rd_act_q, rd_hit;
  logic [7:0] ob_q;

  // register window is open only while M2 is high
  assign io_ce_n    = ~m2_i;
  assign rd_hit     = sel_i & rw_i & (addr_i == ADDR_W'(STAT_ADDR)) & ~io_ce_n;
  assign rd_start_o = rd_hit & ~m2_q;
  assign rd_end_o   = rd_act_q & io_ce_n;
  assign ob_o       = ob_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m2_q     <= 1'b0;
      rd_act_q <= 1'b0;
      ob_q     <= '0;
    end else begin
      m2_q <= m2_i;
      if (rd_start_o)   rd_act_q <= 1'b1;
      else if (io_ce_n) rd_act_q <= 1'b0;
      if (sel_i && !rw_i && !io_ce_n) ob_q <= data_i;
    end
  end
endmodule

// File: rtl/stat_flag_lag.sv
module stat_flag_lag #(
  parameter int unsigned LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic step_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_nx_o
);
  localparam int unsigned CNT_W = $clog2(LAG + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LAG + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_comb begin
    flag_nx_o = flag_q;
    if (step_i && cnt_q == CNT_W'(1)) flag_nx_o = 1'b1;
    if (clr_i) flag_nx_o = 1'b0;
  end

  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_nx_o;
      if (clr_i)                       cnt_q <= '0;
      else if (ev_i)                   cnt_q <= LOAD;
      else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/stat_vblank.sv
module stat_vblank #(
  parameter int unsigned POS_W    = 9,
  parameter int unsigned VBL_LINE = 241,
  parameter int unsigned PRE_LINE = 261,
  parameter int unsigned SET_DOT  = 1,
  parameter int unsigned RACE_WIN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pclk0_i,
  input  logic             pclk1_i,
  input  logic [POS_W-1:0] line_i,
  input  logic [POS_W-1:0] dot_i,
  input  logic             rd_start_i,
  input  logic             rd_end_i,
  input  logic             nmi_en_i,
  output logic             vbl_o,
  output logic             vbl_nx_o,
  output logic             pre_pt_o,
  output logic             nmi_o
);
  localparam int unsigned CW = $clog2(RACE_WIN + 2);
  localparam logic [CW-1:0] SAT = CW'(RACE_WIN + 1);
  localparam logic [CW-1:0] WIN = CW'(RACE_WIN);

  logic          set_pt, hd, vbl_q, blk_q, blk_nx;
  logic [CW-1:0] since_set_q, since_rd_q;

  assign set_pt   = pclk0_i & (line_i == POS_W'(VBL_LINE)) & (dot_i == POS_W'(SET_DOT));
  assign pre_pt_o = pclk0_i & (line_i == POS_W'(PRE_LINE)) & (dot_i == POS_W'(SET_DOT));
  assign hd       = pclk0_i | pclk1_i;

  always_comb begin
    vbl_nx_o = vbl_q;
    if (set_pt)   vbl_nx_o = 1'b1;
    if (rd_end_i) vbl_nx_o = 1'b0;
    if (pre_pt_o) vbl_nx_o = 1'b0;
  end

  // race: read start within the window on either side of the set point
  always_comb begin
    blk_nx = blk_q;
    if (set_pt && (rd_start_i || since_rd_q <= WIN)) blk_nx = 1'b1;
    if (rd_start_i && since_set_q <= WIN)            blk_nx = 1'b1;
    if (pre_pt_o)                                    blk_nx = 1'b0;
  end

  assign vbl_o = vbl_q;
  // hold NMI until the race window has closed
  assign nmi_o = vbl_q & nmi_en_i & ~blk_q & (since_set_q == SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbl_q       <= 1'b0;
      blk_q       <= 1'b0;
      since_set_q <= SAT;
      since_rd_q  <= SAT;
    end else begin
      vbl_q <= vbl_nx_o;
      blk_q <= blk_nx;
      if (set_pt)                     since_set_q <= CW'(1);
      else if (hd && since_set_q != SAT) since_set_q <= since_set_q + CW'(1);
      if (rd_start_i)                 since_rd_q <= CW'(1);
      else if (hd && since_rd_q != SAT)  since_rd_q <= since_rd_q + CW'(1);
    end
  end
endmodule

// File: rtl/ppu_status_nmi.sv
module ppu_status_nmi
  import ppu_stat_pkg::*;
#(
  parameter int unsigned POS_W     = 9,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 2,
  parameter int unsigned VBL_LINE  = 241,
  parameter int unsigned PRE_LINE  = 261,
  parameter int unsigned SET_DOT   = 1,
  parameter int unsigned RACE_WIN  = 6,
  parameter int unsigned HIT_LAG   = 2,
  parameter int unsigned OVF_LAG   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk0_i,
  input  logic              pclk1_i,
  input  logic [POS_W-1:0]  line_i,
  input  logic [POS_W-1:0]  dot_i,
  input  logic              m2_i,
  input  logic              sel_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              nmi_en_i,
  input  logic              s0_hit_i,
  input  logic              ovf_i,
  output logic [7:0]        status_o,
  output logic              nmi_o
);
  logic               rd_start, rd_end, vbl_flag, vbl_nx, pre_pt;
  logic [7:0]         ob;
  logic [NUM_HIT-1:0] hit_ev, hit_flag, hit_nx;
  logic [7:0]         status_q;

  stat_bus #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_bus (
    .clk_i, .rst_ni, .m2_i, .sel_i, .rw_i, .addr_i, .data_i,
    .rd_start_o(rd_start), .rd_end_o(rd_end), .ob_o(ob)
  );

  stat_vblank #(
    .POS_W(POS_W), .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE),
    .SET_DOT(SET_DOT), .RACE_WIN(RACE_WIN)
  ) u_vbl (
    .clk_i, .rst_ni, .pclk0_i, .pclk1_i, .line_i, .dot_i,
    .rd_start_i(rd_start), .rd_end_i(rd_end), .nmi_en_i,
    .vbl_o(vbl_flag), .vbl_nx_o(vbl_nx), .pre_pt_o(pre_pt), .nmi_o
  );

  assign hit_ev[HIT_S0]  = s0_hit_i;
  assign hit_ev[HIT_OVF] = ovf_i;

  for (genvar g = 0; g < NUM_HIT; g++) begin : g_lag
    localparam int unsigned LAG = (g == HIT_S0) ? HIT_LAG : OVF_LAG;
    stat_flag_lag #(.LAG(LAG)) u_lag (
      .clk_i, .rst_ni, .ev_i(hit_ev[g]), .step_i(pclk1_i), .clr_i(pre_pt),
      .flag_o(hit_flag[g]), .flag_nx_o(hit_nx[g])
    );
  end

  // capture includes a flag being set on this very half-dot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_q <= '0;
    else if (rd_start) status_q <= {vbl_nx, hit_nx[HIT_S0], hit_nx[HIT_OVF], ob[OB_W-1:0]};
  end

  assign status_o = status_q;
endmodule

// File: rtl/ppu_status_nmi_chk.sv
module ppu_status_nmi_chk #(
  parameter int unsigned POS_W     = 9,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 2,
  parameter int unsigned VBL_LINE  = 241,
  parameter int unsigned PRE_LINE  = 261,
  parameter int unsigned SET_DOT   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pclk0_i,
  input logic              pclk1_i,
  input logic [POS_W-1:0]  line_i,
  input logic [POS_W-1:0]  dot_i,
  input logic              m2_i,
  input logic              sel_i,
  input logic              rw_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              nmi_en_i,
  input logic [7:0]        status_o,
  input logic              nmi_o,
  input logic              vbl_flag,
  input logic [1:0]        hit_flag
);
  logic m2_q, set_pt, pre_pt, rd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  assign set_pt  = pclk0_i && line_i == POS_W'(VBL_LINE) && dot_i == POS_W'(SET_DOT);
  assign pre_pt  = pclk0_i && line_i == POS_W'(PRE_LINE) && dot_i == POS_W'(SET_DOT);
  assign rd_rise = sel_i && rw_i && addr_i == ADDR_W'(STAT_ADDR) && m2_i && !m2_q;

  assert_vbl_set_point_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vbl_flag) |-> $past(set_pt));
  assert_vbl_clear_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vbl_flag) |-> ($past(pre_pt) || ($past(m2_q) && !$past(m2_i))));
  assert_nmi_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (nmi_en_i && vbl_flag));
  assert_hit_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_flag[0]) |-> $past(pclk1_i));
  assert_ovf_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_flag[1]) |-> $past(pclk1_i));
  assert_pre_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_pt |=> (!vbl_flag && hit_flag == 2'b00 && !nmi_o));
  assert_status_update_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> $past(rd_rise));
endmodule

bind ppu_status_nmi ppu_status_nmi_chk #(
  .POS_W(POS_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
  .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .SET_DOT(SET_DOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pclk0_i(pclk0_i), .pclk1_i(pclk1_i),
  .line_i(line_i), .dot_i(dot_i), .m2_i(m2_i), .sel_i(sel_i), .rw_i(rw_i),
  .addr_i(addr_i), .nmi_en_i(nmi_en_i), .status_o(status_o), .nmi_o(nmi_o),
  .vbl_flag(vbl_flag), .hit_flag(hit_flag)
);

// File: tb/ppu_status_nmi_test.sv
module ppu_status_nmi_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pclk0 = 0, pclk1 = 0, m2 = 0, sel = 0, rw = 1, nmi_en = 0, s0 = 0, ovf = 0;
  logic [8:0] line = '0, dot = '0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] status;
  logic       nmi;

  always #5 clk = ~clk;

  ppu_status_nmi uut (
    .clk_i(clk), .rst_ni(rst_ni), .pclk0_i(pclk0), .pclk1_i(pclk1),
    .line_i(line), .dot_i(dot), .m2_i(m2), .sel_i(sel), .rw_i(rw),
    .addr_i(addr), .data_i(data), .nmi_en_i(nmi_en), .s0_hit_i(s0),
    .ovf_i(ovf), .status_o(status), .nmi_o(nmi)
  );

  int checks = 0, errors = 0;
  int line_r = 0, dot_r = 0, ph = 0, hd = 0;
  logic nx_m2 = 0, nx_sel = 0, nx_rw = 1, nx_en = 0, nx_s0 = 0, nx_ovf = 0;
  logic [2:0] nx_addr = '0;
  logic [7:0] nx_data = '0, ob_model = '0;
  logic nmi_seen = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];
  event rd_done;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    pclk0 = (ph == 0); pclk1 = (ph == 1);
    line = line_r[8:0]; dot = dot_r[8:0];
    m2 = nx_m2; sel = nx_sel; rw = nx_rw; addr = nx_addr; data = nx_data;
    nmi_en = nx_en; s0 = nx_s0; ovf = nx_ovf;
    nx_s0 = 0; nx_ovf = 0;
    if (ph == 1) begin
      dot_r++;
      if (dot_r == 341) begin dot_r = 0; line_r = (line_r + 1) % 262; end
    end
    ph ^= 1; hd++;
  endtask

  task automatic run_to(input int idx);
    while (hd < idx) tick();
  endtask

  task automatic restart(input int l, input int d);
    rst_ni = 0; nx_m2 = 0; nx_sel = 0; nx_rw = 1; nx_en = 1;
    line_r = 0; dot_r = 0; ph = 0;
    tick(); tick();
    @(negedge clk); rst_ni = 1;
    line_r = l; dot_r = d; ph = 0; hd = 0; nmi_seen = 0; ob_model = '0;
  endtask

  // driver: status read whose M2 rise lands on the current index
  task automatic do_read(input logic [2:0] flags, input string req);
    item_t it;
    nx_m2 = 1; nx_sel = 1; nx_rw = 1; nx_addr = 3'd2;
    tick(); tick();
    nx_m2 = 0; nx_sel = 0;
    tick();
    it.exp = {flags, ob_model[4:0]}; it.req = req;
    sb_q.push_back(it);
    ->rd_done;
  endtask

  // monitor
  initial forever begin
    item_t it;
    @(rd_done);
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(status === it.exp, it.req, status, it.exp);
    end
  end

  always @(negedge clk) if (rst_ni && nmi === 1'b1) nmi_seen = 1;

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    restart(240, 330);
    tick();
    chk(status === 8'h00, "R1 status", status, 8'h00);
    chk(nmi === 1'b0, "R1 nmi", {7'd0, nmi}, 8'h00);

    // R2 R3 R5 race sweep, set point at index 24
    for (int d = -8; d <= 8; d++) begin
      restart(240, 330);
      run_to(24 + d);
      do_read((d >= 0) ? 3'b100 : 3'b000, "R2 R3 race read bit");
      run_to(50);
      chk(nmi_seen == ((d < -6) || (d > 6)), "R5 nmi after race read",
          {7'd0, nmi_seen}, {7'd0, (d < -6) || (d > 6)});
    end

    // R4 R6 clear on read
    restart(240, 330);
    run_to(40);
    chk(nmi === 1'b1, "R6 nmi raised", {7'd0, nmi}, 8'h01);
    do_read(3'b100, "R4 first read");
    tick();
    chk(nmi === 1'b0, "R4 nmi drops after read", {7'd0, nmi}, 8'h00);
    do_read(3'b000, "R4 second read");

    // R6 late enable
    restart(240, 330);
    nx_en = 0;
    run_to(40);
    chk(nmi === 1'b0, "R6 disabled", {7'd0, nmi}, 8'h00);
    nx_en = 1;
    tick(); tick();
    chk(nmi === 1'b1, "R6 late enable", {7'd0, nmi}, 8'h01);

    // R7 R12 sprite zero two-dot lag
    restart(100, 10);
    nx_s0 = 1; tick(); tick();
    do_read(3'b000, "R7 before lag");
    do_read(3'b010, "R7 at x+2 pclk1");
    tick(); tick(); tick(); tick();
    do_read(3'b010, "R12 hit kept after read");

    // R8 overflow same dot
    restart(100, 10);
    nx_ovf = 1;
    do_read(3'b000, "R8 event half-dot");
    do_read(3'b001, "R8 after pclk1");

    // R9 pre-render clear
    restart(241, 0);
    nx_s0 = 1; nx_ovf = 1;
    run_to(20);
    chk(nmi === 1'b1, "R9 nmi before clear", {7'd0, nmi}, 8'h01);
    line_r = 261; dot_r = 0; ph = 0;
    tick(); tick(); tick(); tick();
    chk(nmi === 1'b0, "R9 nmi after clear", {7'd0, nmi}, 8'h00);
    do_read(3'b000, "R9 flags cleared");

    // R10 R11 open bus and decode
    restart(241, 0);
    run_to(20);
    nx_m2 = 1; nx_sel = 1; nx_rw = 0; nx_addr = 3'd0; nx_data = 8'h35;
    tick(); tick();
    nx_m2 = 0; nx_sel = 0; nx_rw = 1;
    tick(); tick();
    ob_model = 8'h35;
    chk(nmi === 1'b1, "R11 write keeps flag", {7'd0, nmi}, 8'h01);
    nx_m2 = 1; nx_sel = 1; nx_rw = 1; nx_addr = 3'd3;
    tick(); tick();
    nx_m2 = 0; nx_sel = 0;
    tick(); tick();
    chk(nmi === 1'b1, "R11 other read keeps flag", {7'd0, nmi}, 8'h01);
    chk(status === 8'h00, "R11 other read no capture", status, 8'h00);
    do_read(3'b100, "R10 open bus low bits");
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule